// File: doc/BRIEF.md
# Compressed Register-Pair Load/Store Decoder

This combinational decoder inspects a 16-bit compressed instruction and recognises the four doubleword load/store forms. Two of them address memory relative to a general base register, and the other two address it relative to the stack pointer. On a 64-bit core each form names a single 64-bit data register. On a 32-bit core with the pair feature switched on, each form names an even/odd register pair that together holds 64 bits, and odd pair registers are rejected.

The block reports the access kind, the base and data register indices, the zero-extended byte offset scaled by eight, and an illegal-instruction flag. A second enable can ask for the compressed single-precision float load/store feature, which uses the same opcodes. The decoder gives the pair feature priority and reports whether the float decoder may take the slot. Any encoding the block does not own deasserts `decValid`, so other decoders in the front end can claim it.

Top module: `pairdec_top`

## Requirements
- R1: `decValid` is 1 only when `instIn[1:0]` is 00 or 10 and `instIn[15:13]` is 011 (load) or 111 (store); for every other 16-bit value it is 0.
- R2: `isStore` equals `instIn[15]` for a recognised form. Quadrant 00 forms use base register `8 + instIn[9:7]`. Quadrant 10 forms use base register x2.
- R3: Base-relative forms give the offset `{instIn[6:5], instIn[12:10], 000}`. Stack load gives `{instIn[4:2], instIn[12], instIn[6:5], 000}`. Stack store gives `{instIn[9:7], instIn[12:10], 000}`. All are zero-extended, so the low three bits are always 0.
- R4: The data register is `8 + instIn[4:2]` for base-relative forms, `instIn[11:7]` for the stack load and `instIn[6:2]` for the stack store.
- R5: In 32-bit mode (`rv64Mode`=0) with pairs enabled, a data register field value of 1, 3, 5 or 7 raises `illegal`. For the 3-bit forms this is any odd field. A 5-bit field value of 9 or higher is not restricted.
- R6: In 32-bit mode with `pairEnable`=0, every recognised form raises `illegal` unless the float decoder takes the slot (R8).
- R7: The stack load with data field 0 raises `illegal` in both modes. The stack store with field 0 does not.
- R8: `fpGrant` = `fpEnable` AND NOT `pairEnable` AND NOT `rv64Mode`. When `fpGrant` is 1, `decValid` is 0 for all four forms.
- R9: In 64-bit mode, no register-pair restriction applies and `pairEnable` has no effect on `illegal`.
- R10: When `decValid` is 0, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instIn | input | 16 | Compressed instruction under decode |
| rv64Mode | input | 1 | 1 = 64-bit core behaviour, 0 = 32-bit |
| pairEnable | input | 1 | Enables register-pair interpretation on a 32-bit core |
| fpEnable | input | 1 | Requests the compressed float load/store feature |
| decValid | output | 1 | Instruction is one of the four owned forms |
| isStore | output | 1 | 1 = store, 0 = load |
| baseReg | output | 5 | Base register index |
| dataReg | output | 5 | Data register index (first of the pair on 32-bit) |
| offset | output | 9 | Zero-extended byte offset, multiple of 8 |
| illegal | output | 1 | Reserved or disabled encoding |
| fpGrant | output | 1 | Float decoder may claim these opcodes |

## Verification
The hardest case is the interaction between the two enables and the mode. A 32-bit core with only the float feature requested must hand the slot away, so `decValid` falls. With both enables set, the pair feature must win. With neither set, the form must be owned and still flagged illegal. The stimulus table repeats the same load encoding under each enable combination. It also places odd data fields just below and above eight in the stack forms, which separates the reserved values from the unrestricted ones.

// File: rtl/pairdec_pkg.sv
package pairdec_pkg;
  localparam int REG_W = 5;
  localparam int OFF_W = 9;

  typedef struct packed {
    logic hit;
    logic isStore;
    logic stackRel;
  } decStrobe_t;
endpackage

// File: rtl/pairdec_ctrl.sv
module pairdec_ctrl
  import pairdec_pkg::*;
#(
  parameter int FIELD_W = 5
) (
  input  logic [15:0] instIn,
  input  logic        rv64Mode,
  input  logic        pairEnable,
  input  logic        fpEnable,
  output decStrobe_t  strobe,
  output logic        illegal,
  output logic        fpGrant
);
  localparam logic [1:0] QUAD_BASE  = 2'b00;
  localparam logic [1:0] QUAD_STACK = 2'b10;
  localparam logic [2:0] F3_LOAD    = 3'b011;
  localparam logic [2:0] F3_STORE   = 3'b111;
  localparam int PAIR_LIMIT = 8;

  logic [1:0] quad;
  logic [2:0] funct3;
  logic formMatch, stackRel, storeOp;
  logic [FIELD_W-1:0] dataField;
  logic pairReserved, zeroLoad;

  always_comb begin
    quad      = instIn[1:0];
    funct3    = instIn[15:13];
    storeOp   = (funct3 == F3_STORE);
    stackRel  = (quad == QUAD_STACK);
    formMatch = ((funct3 == F3_LOAD) || (funct3 == F3_STORE)) &&
                ((quad == QUAD_BASE) || (quad == QUAD_STACK));
    if (!stackRel)      dataField = FIELD_W'(instIn[4:2]);
    else if (storeOp)   dataField = instIn[6:2];
    else                dataField = instIn[11:7];
  end

  always_comb begin
    pairReserved = (int'(dataField) < PAIR_LIMIT) && dataField[0];
    zeroLoad     = stackRel && !storeOp && (dataField == '0);
    fpGrant      = fpEnable && !pairEnable && !rv64Mode;
    strobe.hit      = formMatch && !fpGrant;
    strobe.isStore  = storeOp;
    strobe.stackRel = stackRel;
    illegal = strobe.hit &&
              (zeroLoad || (!rv64Mode && (!pairEnable || pairReserved)));
  end
endmodule

// File: rtl/pairdec_dpath.sv
module pairdec_dpath
  import pairdec_pkg::*;
#(
  parameter int RW = 5,
  parameter int OW = 9,
  parameter int CREG_BIAS = 8,
  parameter int SP_INDEX = 2
) (
  input  logic [15:0]   instIn,
  input  decStrobe_t    strobe,
  output logic [RW-1:0] baseReg,
  output logic [RW-1:0] dataReg,
  output logic [OW-1:0] offset
);
  localparam int NCREG = 2;
  localparam int SCALE_BITS = 3;

  logic [2:0] cField [NCREG];
  logic [RW-1:0] cFull [NCREG];

  assign cField[0] = instIn[9:7];
  assign cField[1] = instIn[4:2];

  for (genvar g = 0; g < NCREG; g++) begin : g_expand
    assign cFull[g] = RW'(cField[g]) + RW'(CREG_BIAS);
  end

  logic [8:0] rawOff;

  always_comb begin
    if (!strobe.stackRel) begin
      baseReg = cFull[0];
      dataReg = cFull[1];
      rawOff  = {1'b0, instIn[6:5], instIn[12:10], {SCALE_BITS{1'b0}}};
    end else if (strobe.isStore) begin
      baseReg = RW'(SP_INDEX);
      dataReg = instIn[6:2];
      rawOff  = {instIn[9:7], instIn[12:10], {SCALE_BITS{1'b0}}};
    end else begin
      baseReg = RW'(SP_INDEX);
      dataReg = instIn[11:7];
      rawOff  = {instIn[4:2], instIn[12], instIn[6:5], {SCALE_BITS{1'b0}}};
    end
    offset = OW'(rawOff);
  end
endmodule

// File: rtl/pairdec_top.sv
module pairdec_top
  import pairdec_pkg::*;
(
  input  logic [15:0]      instIn,
  input  logic             rv64Mode,
  input  logic             pairEnable,
  input  logic             fpEnable,
  output logic             decValid,
  output logic             isStore,
  output logic [REG_W-1:0] baseReg,
  output logic [REG_W-1:0] dataReg,
  output logic [OFF_W-1:0] offset,
  output logic             illegal,
  output logic             fpGrant
);
  decStrobe_t strobe;

  pairdec_ctrl #(.FIELD_W(REG_W)) ctrl_i (
    .instIn(instIn), .rv64Mode(rv64Mode), .pairEnable(pairEnable),
    .fpEnable(fpEnable), .strobe(strobe), .illegal(illegal), .fpGrant(fpGrant)
  );

  pairdec_dpath #(.RW(REG_W), .OW(OFF_W)) dpath_i (
    .instIn(instIn), .strobe(strobe), .baseReg(baseReg),
    .dataReg(dataReg), .offset(offset)
  );

  assign decValid = strobe.hit;
  assign isStore  = strobe.isStore;
endmodule

// File: rtl/pairdec_checker.sv
module pairdec_checker
  import pairdec_pkg::*;
(
  input logic [15:0]      instIn,
  input logic             rv64Mode,
  input logic             pairEnable,
  input logic             decValid,
  input logic             isStore,
  input logic [REG_W-1:0] baseReg,
  input logic [REG_W-1:0] dataReg,
  input logic [OFF_W-1:0] offset,
  input logic             illegal,
  input logic             fpGrant
);
  always_comb begin
    a_r1_no_compressed32: assert (!(decValid && instIn[1:0] == 2'b11));
    a_r3_offset_aligned: assert (!decValid || offset[2:0] == 3'b000);
    a_r5_even_pair: assert (!(decValid && !illegal && !rv64Mode &&
                              dataReg < 5'd8 && dataReg[0]));
    a_r6_disabled_illegal: assert (!(decValid && !rv64Mode && !pairEnable) || illegal);
    a_r7_load_x0: assert (!(decValid && !isStore && baseReg == 5'd2 &&
                            dataReg == 5'd0) || illegal);
    a_r8_exclusive: assert (!(fpGrant && pairEnable));
    a_r10_quiet_illegal: assert (decValid || !illegal);
  end
endmodule

bind pairdec_top pairdec_checker chk_i (
  .instIn(instIn), .rv64Mode(rv64Mode), .pairEnable(pairEnable),
  .decValid(decValid), .isStore(isStore), .baseReg(baseReg),
  .dataReg(dataReg), .offset(offset), .illegal(illegal), .fpGrant(fpGrant)
);

// File: tb/pairdec_tb_top.sv
module pairdec_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] instIn;
  logic rv64Mode, pairEnable, fpEnable;
  logic decValid, isStore, illegal, fpGrant;
  logic [4:0] baseReg, dataReg;
  logic [8:0] offset;

  pairdec_top dut_i (
    .instIn(instIn), .rv64Mode(rv64Mode), .pairEnable(pairEnable),
    .fpEnable(fpEnable), .decValid(decValid), .isStore(isStore),
    .baseReg(baseReg), .dataReg(dataReg), .offset(offset),
    .illegal(illegal), .fpGrant(fpGrant)
  );

  int errCount = 0;
  int chkCount = 0;
  bit finished = 0;

  // form: 0 base load, 1 base store, 2 stack load, 3 stack store
  typedef struct packed {
    logic [1:0] form;
    logic [4:0] field;
    logic [2:0] rs;
    logic [8:0] off;
    logic rv64, pen, fen;
    logic expValid, expIll;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 5'd2,  3'd3, 9'h0F8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 R3 R4
    '{2'd1, 5'd4,  3'd0, 9'h008, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R2
    '{2'd0, 5'd5,  3'd1, 9'h040, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    '{2'd1, 5'd7,  3'd6, 9'h0B0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    '{2'd0, 5'd5,  3'd7, 9'h0C8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
    '{2'd2, 5'd10, 3'd0, 9'h1F8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
    '{2'd2, 5'd3,  3'd0, 9'h128, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    '{2'd2, 5'd0,  3'd0, 9'h010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R7
    '{2'd2, 5'd0,  3'd0, 9'h020, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7
    '{2'd3, 5'd0,  3'd0, 9'h1F8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7
    '{2'd3, 5'd5,  3'd0, 9'h0E8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    '{2'd3, 5'd9,  3'd0, 9'h158, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5
    '{2'd0, 5'd2,  3'd4, 9'h018, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6
    '{2'd0, 5'd2,  3'd4, 9'h018, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
    '{2'd0, 5'd2,  3'd4, 9'h018, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8
    '{2'd3, 5'd1,  3'd0, 9'h0A0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R9
    '{2'd2, 5'd1,  3'd0, 9'h1C8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R9
  };

  function automatic logic [15:0] encode(vec_t v);
    case (v.form)
      2'd0: return {3'b011, v.off[5:3], v.rs, v.off[7:6], v.field[2:0], 2'b00};
      2'd1: return {3'b111, v.off[5:3], v.rs, v.off[7:6], v.field[2:0], 2'b00};
      2'd2: return {3'b011, v.off[5], v.field, v.off[4:3], v.off[8:6], 2'b10};
      default: return {3'b111, v.off[5:3], v.off[8:6], v.field, 2'b10};
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] i, logic r, logic p, logic f);
    @(posedge clk);
    instIn = i; rv64Mode = r; pairEnable = p; fpEnable = f;
    @(negedge clk);
  endtask

  initial begin
    instIn = 16'h0000; rv64Mode = 1'b0; pairEnable = 1'b0; fpEnable = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle: all-zero word is not owned
    check("R1", "idle valid", int'(decValid), 0);
    check("R10", "idle illegal", int'(illegal), 0);

    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = TBL[k];
      apply(encode(v), v.rv64, v.pen, v.fen);
      check("R8", "fpGrant", int'(fpGrant), int'(v.fen && !v.pen && !v.rv64));
      check("R1", "valid", int'(decValid), int'(v.expValid));
      check("R5", "illegal", int'(illegal), int'(v.expIll));
      if (v.expValid) begin
        check("R2", "isStore", int'(isStore), int'(v.form[0]));
        check("R2", "baseReg", int'(baseReg), v.form[1] ? 2 : int'(v.rs) + 8);
        check("R4", "dataReg", int'(dataReg),
              v.form[1] ? int'(v.field) : int'(v.field[2:0]) + 8);
        check("R3", "offset", int'(offset), int'(v.off));
      end
    end

    // R9: pairEnable has no effect in 64-bit mode for an odd 3-bit field
    apply({3'b011, 3'b000, 3'd1, 2'b00, 3'd3, 2'b00}, 1'b1, 1'b1, 1'b0);
    check("R9", "rv64 pen=1 illegal", int'(illegal), 0);
    apply({3'b011, 3'b000, 3'd1, 2'b00, 3'd3, 2'b00}, 1'b1, 1'b0, 1'b0);
    check("R9", "rv64 pen=0 illegal", int'(illegal), 0);
    // R1: neighbours of the owned opcodes
    apply(16'h2000, 1'b0, 1'b1, 1'b0);
    check("R1", "funct3 001 q00", int'(decValid), 0);
    apply(16'h6003, 1'b0, 1'b1, 1'b0);
    check("R1", "funct3 011 q11", int'(decValid), 0);
    apply(16'hE001, 1'b0, 1'b1, 1'b0);
    check("R1", "funct3 111 q01", int'(decValid), 0);
    check("R10", "unowned illegal", int'(illegal), 0);
    apply(16'h4502, 1'b0, 1'b1, 1'b0);
    check("R1", "funct3 010 q10", int'(decValid), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end
endmodule